// File: doc/BRIEF.md
# Serial Register-Port Slave with Deferred Status Clear

This block lets a host controller reach a 32-location register space over a four-wire serial link. Every transaction opens with a header byte. The top bit of the header asks for a command. The next bit asks for a read. The bit after that asks for continuous (auto-incrementing) access. The low five bits hold the address. Data bytes follow the header, most significant bit first. Each completed byte appears on the register side as a one-cycle write or read strobe, and the address and data sit beside the strobe. The register functions themselves sit outside the block. There are two exceptions. The block holds the sticky interrupt status word, which it serves at its status address. It also decodes command bytes into strobes.

The serial pins are sampled by the system clock through synchronisers, so the serial clock must run well below the system clock. Two framing modes exist. With the select line, a low level frames a transaction. Without it, a transaction opens when the data line falls while the serial clock is high, and it closes when the data line rises while the serial clock is high. A byte that is cut off by the end of a frame has no effect. Status bits are cleared only by a continuous read of the status address that goes on to read one more (dummy) byte. The clear removes only the bits the host was shown.

Top module: `spi_regport`

## Requirements
- R1: The header byte is decoded as bit 7 command, bit 6 read, bit 5 continuous, bits 4:0 address; all bytes on the data-in line are taken most significant bit first, one bit per rising serial clock edge.
- R2: In a write, each completed data byte gives exactly one `reg_wr` pulse carrying the current address and the byte; in single (non-continuous) mode only the first data byte is written and later bytes are ignored; a byte cut short by the end of the frame produces no strobe.
- R3: In continuous mode the address steps by one after every completed data byte, read or write, and stays at 0x1F once it gets there, so further bytes keep going to 0x1F.
- R4: Read data leaves on `spi_miso` most significant bit first; each bit changes after a rising serial clock edge so the host samples it on the falling edge; the first bit of a data byte appears at the first clock of that byte; each completed read byte gives one `reg_rd` pulse for the address that was read.
- R5: Address 0x0C reads the internal status word; any bit set on `irq_set` becomes sticky in that word one cycle later, and `irq` is high whenever any status bit is set.
- R6: Status bits are cleared only when, in a continuous read that began with address 0x0C, the following byte (address 0x0D) completes; only the bits that were shifted out at 0x0C are cleared; a single read of 0x0C, or a frame that ends after the 0x0C byte, clears nothing.
- R7: A header with bit 7 set gives a one-cycle `cmd_strobe` with `cmd_code` equal to header bits 4:0, and starts no data phase (later bytes make no strobe); code 0x0F additionally pulses `fifo_clear`.
- R8: With `cfg_use_ss` high, `spi_ss_n` low frames a transaction and its rise ends it, discarding any partial byte.
- R9: With `cfg_use_ss` low, `spi_ss_n` is ignored; a fall of `spi_mosi` while `spi_sclk` is high starts a transaction and a rise of `spi_mosi` while `spi_sclk` is high ends it.
- R10: Outside a transaction, `spi_miso_oe` is low and `spi_miso` is released to high impedance; after reset no strobe is active and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_use_ss | input | 1 | 1: frame with the select line, 0: frame with start/stop conditions |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_ss_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, high impedance when idle |
| spi_miso_oe | output | 1 | High while `spi_miso` is driven |
| reg_addr | output | 5 | Register address for the current access |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read-completed strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for `reg_addr`, combinational from the register file |
| irq_set | input | 8 | Status bits to set |
| irq | output | 1 | OR of the status word |
| cmd_strobe | output | 1 | One-cycle command strobe |
| cmd_code | output | 5 | Command code from the header |
| fifo_clear | output | 1 | One-cycle FIFO clear request |

## Verification
The hardest case to reach is the partial status clear. It needs a status bit that arrives after the 0x0C byte has been loaded into the shifter but before the dummy byte completes. The bench gets there by pulsing `irq_set` in the gap between the two bytes of one continuous status read. It then reads the word again to show that only the new bit is left. A second hard case is the stop condition in start/stop mode. It adds a rising clock edge of its own, which loads a read byte without completing it, so the bench checks that the read count and the FIFO pop count stay unchanged across each stop.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PH_HDR,
        PH_WR,
        PH_RD,
        PH_IGN
    } phase_e;

    typedef struct packed {
        logic              cmd;
        logic              rd;
        logic              cont;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    function automatic hdr_t decode_hdr(input logic [DATA_W-1:0] b);
        return hdr_t'(b);
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] last
    );
        return (a == last) ? a : a + 1'b1;
    endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int               WIDTH  = 3,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] INIT   = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dly
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {STAGES{INIT[b]}};
                prev  <= INIT[b];
            end else begin
                chain <= {chain[STAGES-2:0], din[b]};
                prev  <= chain[STAGES-1];
            end
        end

        assign dout[b] = chain[STAGES-1];
        assign dly[b]  = prev;
    end

endmodule

// File: rtl/spi_regport_framer.sv
module spi_regport_framer (
    input  logic clk,
    input  logic rst,
    input  logic use_ss,
    input  logic ss_n,
    input  logic ss_fall,
    input  logic sclk,
    input  logic mosi_rise,
    input  logic mosi_fall,
    output logic active,
    output logic frame_start
);

    logic start_cond;
    logic stop_cond;

    assign start_cond  = mosi_fall & sclk;
    assign stop_cond   = mosi_rise & sclk;
    assign frame_start = use_ss ? ss_fall : start_cond;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
        end else if (use_ss) begin
            active <= ~ss_n;
        end else if (stop_cond) begin
            active <= 1'b0;
        end else if (start_cond) begin
            active <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_regport_shifter.sv
module spi_regport_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            sclk_rise,
    input  logic            mosi,
    input  logic [BITS-1:0] load_val,
    output logic            byte_done,
    output logic [BITS-1:0] rx_byte,
    output logic [BITS-1:0] shown,
    output logic            miso
);

    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

    logic [CNT_W-1:0] cnt;
    logic [BITS-1:0]  tx;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt       <= '0;
            rx_byte   <= '0;
            tx        <= '0;
            shown     <= '0;
            miso      <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (sclk_rise) begin
                rx_byte   <= {rx_byte[BITS-2:0], mosi};
                cnt       <= (cnt == LAST) ? '0 : cnt + 1'b1;
                byte_done <= (cnt == LAST);
                if (cnt == '0) begin
                    miso  <= load_val[BITS-1];
                    tx    <= {load_val[BITS-2:0], 1'b0};
                    shown <= load_val;
                end else begin
                    miso  <= tx[BITS-1];
                    tx    <= {tx[BITS-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/spi_regport_status.sv
module spi_regport_status #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_bits,
    input  logic         clr,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status,
    output logic         irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= (clr ? (status & ~clr_mask) : status) | set_bits;
        end
    end

    assign irq = |status;

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 5'h0C,
    parameter logic [ADDR_W-1:0] FIFO_ADDR   = 5'h1F,
    parameter logic [ADDR_W-1:0] CLR_CODE    = 5'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_use_ss,
    input  logic              spi_sclk,
    input  logic              spi_ss_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] irq_set,
    output logic              irq,
    output logic              cmd_strobe,
    output logic [ADDR_W-1:0] cmd_code,
    output logic              fifo_clear
);

    localparam int PIN_N  = 3;
    localparam int P_SCLK = 0;
    localparam int P_MOSI = 1;
    localparam int P_SS   = 2;

    logic [PIN_N-1:0] pins_s;
    logic [PIN_N-1:0] pins_d;
    logic sclk_rise, mosi_rise, mosi_fall, ss_fall;
    logic active, frame_start, restart;

    logic              byte_done, done_v, miso_q;
    logic [DATA_W-1:0] rx_byte, shown, load_val, status, snap;
    hdr_t              hdr;
    phase_e            phase;
    logic [ADDR_W-1:0] addr;
    logic              cont, pend, st_clr;

    spi_regport_sync #(
        .WIDTH (PIN_N),
        .STAGES(SYNC_STAGES),
        .INIT  (3'b110)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({spi_ss_n, spi_mosi, spi_sclk}),
        .dout(pins_s),
        .dly (pins_d)
    );

    assign sclk_rise = pins_s[P_SCLK] & ~pins_d[P_SCLK];
    assign mosi_rise = pins_s[P_MOSI] & ~pins_d[P_MOSI];
    assign mosi_fall = ~pins_s[P_MOSI] & pins_d[P_MOSI];
    assign ss_fall   = ~pins_s[P_SS] & pins_d[P_SS];

    spi_regport_framer u_framer (
        .clk        (clk),
        .rst        (rst),
        .use_ss     (cfg_use_ss),
        .ss_n       (pins_s[P_SS]),
        .ss_fall    (ss_fall),
        .sclk       (pins_s[P_SCLK]),
        .mosi_rise  (mosi_rise),
        .mosi_fall  (mosi_fall),
        .active     (active),
        .frame_start(frame_start)
    );

    assign restart = ~active | frame_start;

    spi_regport_shifter #(
        .BITS(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (restart),
        .sclk_rise(sclk_rise & active),
        .mosi     (pins_s[P_MOSI]),
        .load_val (load_val),
        .byte_done(byte_done),
        .rx_byte  (rx_byte),
        .shown    (shown),
        .miso     (miso_q)
    );

    assign done_v = byte_done & active;
    assign st_clr = done_v & (phase == PH_RD) & pend;

    spi_regport_status #(
        .W(DATA_W)
    ) u_status (
        .clk     (clk),
        .rst     (rst),
        .set_bits(irq_set),
        .clr     (st_clr),
        .clr_mask(snap),
        .status  (status),
        .irq     (irq)
    );

    assign hdr = decode_hdr(rx_byte);

    always_comb begin
        if (phase == PH_RD) begin
            load_val = (addr == STATUS_ADDR) ? status : reg_rdata;
        end else begin
            load_val = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= PH_HDR;
            addr  <= '0;
            cont  <= 1'b0;
            pend  <= 1'b0;
            snap  <= '0;
        end else if (done_v) begin
            unique case (phase)
                PH_HDR: begin
                    addr <= hdr.addr;
                    cont <= hdr.cont;
                    if (hdr.cmd)     phase <= PH_IGN;
                    else if (hdr.rd) phase <= PH_RD;
                    else             phase <= PH_WR;
                end
                PH_WR: begin
                    if (cont) addr  <= step_addr(addr, FIFO_ADDR);
                    else      phase <= PH_IGN;
                end
                PH_RD: begin
                    pend <= cont & (addr == STATUS_ADDR);
                    snap <= shown;
                    if (cont) addr  <= step_addr(addr, FIFO_ADDR);
                    else      phase <= PH_IGN;
                end
                default: ;
            endcase
        end
    end

    assign reg_addr    = addr;
    assign reg_wdata   = rx_byte;
    assign reg_wr      = done_v & (phase == PH_WR);
    assign reg_rd      = done_v & (phase == PH_RD);
    assign cmd_strobe  = done_v & (phase == PH_HDR) & hdr.cmd;
    assign cmd_code    = hdr.addr;
    assign fifo_clear  = cmd_strobe & (hdr.addr == CLR_CODE);
    assign spi_miso_oe = active;
    assign spi_miso    = active ? miso_q : 1'bz;

endmodule

// File: rtl/spi_regport_checker.sv
module spi_regport_checker
    import spi_regport_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 5'h0C,
    parameter logic [ADDR_W-1:0] FIFO_ADDR   = 5'h1F,
    parameter logic [ADDR_W-1:0] CLR_CODE    = 5'h0F
) (
    input logic              clk,
    input logic              rst,
    input logic              active,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              cmd_strobe,
    input logic [ADDR_W-1:0] cmd_code,
    input logic              fifo_clear,
    input logic              irq,
    input logic [DATA_W-1:0] irq_set
);

    logic              seen;
    logic [ADDR_W-1:0] last_addr;
    logic              access;

    assign access = reg_wr | reg_rd;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            seen      <= 1'b0;
            last_addr <= '0;
        end else if (access) begin
            seen      <= 1'b1;
            last_addr <= reg_addr;
        end
    end

    assert_addr_saturates_R3: assert property (@(posedge clk) disable iff (rst)
        (access && seen && last_addr == FIFO_ADDR) |-> reg_addr == FIFO_ADDR);

    assert_wr_rd_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    assert_fifo_clear_code_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_clear |-> (cmd_strobe && cmd_code == CLR_CODE));

    assert_cmd_no_data_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |-> (!reg_wr && !reg_rd));

    assert_status_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_set != '0) |=> irq);

    assert_clear_after_dummy_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> ($past(reg_rd) && $past(reg_addr) == STATUS_ADDR + 1'b1));

endmodule

bind spi_regport spi_regport_checker #(
    .STATUS_ADDR(STATUS_ADDR),
    .FIFO_ADDR  (FIFO_ADDR),
    .CLR_CODE   (CLR_CODE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .cmd_strobe(cmd_strobe),
    .cmd_code  (cmd_code),
    .fifo_clear(fifo_clear),
    .irq       (irq),
    .irq_set   (irq_set)
);

// File: tb/spi_regport_bench.sv
`timescale 1ns/1ps
module spi_regport_bench;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_use_ss, sclk, ss_n, mosi;
    logic       spi_miso, spi_miso_oe;
    logic [4:0] reg_addr;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_wdata, reg_rdata, irq_set;
    logic       irq, cmd_strobe, fifo_clear;
    logic [4:0] cmd_code;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int wr_n, rd_n, cmd_n, clr_n, pops;
    logic [4:0] wr_a [64];
    logic [7:0] wr_d [64];
    logic [4:0] last_code;

    always #10 clk = ~clk;

    spi_regport u_spi_regport (
        .clk(clk), .rst(rst), .cfg_use_ss(cfg_use_ss),
        .spi_sclk(sclk), .spi_ss_n(ss_n), .spi_mosi(mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_set(irq_set), .irq(irq),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .fifo_clear(fifo_clear)
    );

    function automatic logic [7:0] model_reg(input logic [4:0] a);
        return {a, 3'b011} ^ 8'h96;
    endfunction

    assign reg_rdata = (reg_addr == 5'h1F) ? (8'hC0 + pops[7:0]) : model_reg(reg_addr);

    initial begin
        wr_n = 0; rd_n = 0; cmd_n = 0; clr_n = 0; pops = 0; last_code = '0;
    end

    always @(posedge clk) begin
        if (!rst) begin
            if (reg_wr && wr_n < 64) begin
                wr_a[wr_n] = reg_addr;
                wr_d[wr_n] = reg_wdata;
                wr_n++;
            end
            if (reg_rd) begin
                rd_n++;
                if (reg_addr == 5'h1F) pops++;
            end
            if (cmd_strobe) begin
                cmd_n++;
                last_code = cmd_code;
            end
            if (fifo_clear) clr_n++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        wr_n = 0; rd_n = 0; cmd_n = 0; clr_n = 0;
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            cyc(HALF);
            sclk = 1'b1;
            cyc(HALF);
            rx[i] = spi_miso;
            sclk = 1'b0;
            cyc(2);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic frame_begin();
        if (cfg_use_ss) begin
            sclk = 1'b0;
            ss_n = 1'b0;
            cyc(HALF);
        end else begin
            sclk = 1'b1; mosi = 1'b1;
            cyc(HALF);
            mosi = 1'b0;
            cyc(HALF);
            sclk = 1'b0;
            cyc(HALF);
        end
    endtask

    task automatic frame_end();
        if (cfg_use_ss) begin
            cyc(HALF);
            ss_n = 1'b1;
            cyc(2 * HALF);
        end else begin
            mosi = 1'b0;
            cyc(HALF);
            sclk = 1'b1;
            cyc(HALF);
            mosi = 1'b1;
            cyc(2 * HALF);
        end
    endtask

    task automatic pulse_irq(input logic [7:0] bits);
        irq_set = bits;
        cyc(1);
        irq_set = '0;
        cyc(2);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] r0, r1, r2, exp_b;
        int p0;
        rst = 1'b1; cfg_use_ss = 1'b1; sclk = 1'b0; mosi = 1'b0; ss_n = 1'b1; irq_set = '0;
        cyc(5);
        rst = 1'b0;
        cyc(5);
        // R10: reset state
        chk("R10 reset oe/irq/strobes", {spi_miso_oe, irq, 8'(cmd_n), 8'(wr_n)}, 32'h0);

        // R1 R2 R8: single write to every address, extra byte ignored
        for (int a = 0; a < 32; a++) begin
            clear_logs();
            frame_begin();
            xfer(8'(a), r0);
            xfer(8'(a * 37 + 11), r0);
            xfer(8'hEE, r0);
            frame_end();
            chk("R2 R1 single write", {8'(wr_n), 3'b0, wr_a[0], wr_d[0]},
                {8'd1, 3'b0, 5'(a), 8'(a * 37 + 11)});
        end

        // R4: single read of every address; extra byte ignored
        for (int a = 0; a < 32; a++) begin
            clear_logs();
            p0 = pops;
            frame_begin();
            xfer(8'h40 | 8'(a), r0);
            xfer(8'h00, r1);
            xfer(8'h00, r2);
            frame_end();
            exp_b = (a == 12) ? 8'h00 : (a == 31) ? 8'(8'hC0 + p0) : model_reg(5'(a));
            chk("R4 single read data", {r0, r1, r2}, {8'h00, exp_b, 8'h00});
            chk("R4 single read strobe count", rd_n, 1);
        end

        // R7: every command code, trailing byte ignored
        for (int c = 0; c < 32; c++) begin
            clear_logs();
            frame_begin();
            xfer(8'h80 | 8'(c), r0);
            xfer(8'h55, r0);
            frame_end();
            chk("R7 command strobe", {8'(cmd_n), 8'(clr_n), 8'(wr_n + rd_n), 3'b0, last_code},
                {8'd1, 8'(c == 15), 8'd0, 3'b0, 5'(c)});
        end

        // R3: continuous write from 0x1D runs into 0x1F and stays
        clear_logs();
        frame_begin();
        xfer(8'h3D, r0);
        for (int k = 0; k < 5; k++) xfer(8'h10 + 8'(k), r0);
        frame_end();
        chk("R3 write count", wr_n, 5);
        for (int k = 0; k < 5; k++)
            chk("R3 write address", {wr_a[k], wr_d[k]},
                {(k < 2) ? 5'(5'h1D + k) : 5'h1F, 8'h10 + 8'(k)});

        // R3 R4: continuous read from 0x1B, four FIFO pops at the end
        clear_logs();
        p0 = pops;
        frame_begin();
        xfer(8'h7B, r0);
        for (int k = 0; k < 8; k++) begin
            xfer(8'h00, r0);
            exp_b = (k < 4) ? model_reg(5'(5'h1B + k)) : 8'(8'hC0 + p0 + k - 4);
            chk("R3 R4 continuous read byte", r0, exp_b);
        end
        frame_end();
        chk("R3 continuous read strobes/pops", {16'(rd_n), 16'(pops - p0)}, {16'd8, 16'd4});

        // R8: partial byte cut by select rise has no effect
        clear_logs();
        frame_begin();
        xfer(8'h05, r0);
        xfer_bits(8'hA5, 4, r0);
        frame_end();
        chk("R8 partial byte dropped", wr_n, 0);
        chk("R10 idle hiz", spi_miso_oe, 1'b0);

        // R5 R6: status word behaviour
        pulse_irq(8'h25);
        chk("R5 irq sticky", irq, 1'b1);
        frame_begin();
        xfer(8'h6C, r0);
        xfer(8'h00, r1);
        frame_end();
        chk("R5 status read value", r1, 8'h25);
        chk("R6 no clear without dummy", irq, 1'b1);
        frame_begin();
        xfer(8'h4C, r0);
        xfer(8'h00, r1);
        xfer(8'h00, r2);
        frame_end();
        chk("R6 no clear in single read", {r1, 7'b0, irq}, {8'h25, 8'h01});
        frame_begin();
        xfer(8'h6C, r0);
        xfer(8'h00, r1);
        pulse_irq(8'h40);
        xfer(8'h00, r2);
        frame_end();
        chk("R6 dummy byte data", {r1, r2}, {8'h25, model_reg(5'h0D)});
        frame_begin();
        xfer(8'h4C, r0);
        xfer(8'h00, r1);
        frame_end();
        chk("R6 only shown bits cleared", {r1, 7'b0, irq}, {8'h40, 8'h01});
        frame_begin();
        xfer(8'h6C, r0);
        xfer(8'h00, r1);
        xfer(8'h00, r2);
        frame_end();
        chk("R6 full clear after dummy", {r1, 7'b0, irq}, {8'h40, 8'h00});

        // R9: start/stop framing, select line ignored
        sclk = 1'b1; mosi = 1'b1; ss_n = 1'b1;
        cyc(4);
        cfg_use_ss = 1'b0;
        cyc(8);
        clear_logs();
        frame_begin();
        chk("R9 frame opened by start", spi_miso_oe, 1'b1);
        xfer(8'h3D, r0);
        xfer(8'hA1, r0);
        xfer(8'hA2, r0);
        xfer(8'hA3, r0);
        frame_end();
        chk("R9 writes and stop partial ignored", {8'(wr_n), 3'b0, wr_a[2], wr_d[2]},
            {8'd3, 3'b0, 5'h1F, 8'hA3});
        chk("R10 idle after stop", spi_miso_oe, 1'b0);
        clear_logs();
        p0 = pops;
        pulse_irq(8'h81);
        frame_begin();
        xfer(8'h7F, r0);
        xfer(8'h00, r1);
        frame_end();
        chk("R9 stop adds no read", {16'(rd_n), 16'(pops - p0)}, {16'd1, 16'd1});
        chk("R4 fifo read in start/stop mode", r1, 8'(8'hC0 + p0));
        frame_begin();
        xfer(8'h6C, r0);
        xfer(8'h00, r1);
        xfer(8'h00, r2);
        frame_end();
        chk("R6 R9 clear in start/stop mode", {r1, 7'b0, irq}, {8'h81, 8'h00});

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule